// File: doc/BRIEF.md
# Fractional-Step Constant-Rate Time Counter

This block keeps a free-running 64-bit time count that advances at a fixed nominal rate, no matter what frequency drives its clock. It does this with a fractional accumulator instead of adding one on every edge. On each clock edge a programmed step value is added to the accumulator. When the sum reaches a programmed modulus, the count goes up by one and the modulus is taken out of the accumulator. Averaged over time, the count therefore moves at `step / modulus` counts per input clock.

To get a 6.144 MHz time base, software sets the step/modulus ratio to 6.144 MHz divided by the input clock frequency. Some example ratios:

- 38.4 MHz → 4/25 (the value loaded at reset)
- 19.2 MHz → 8/25
- 12 MHz → 64/125
- 13 MHz → 768/1625
- 26 MHz → 384/1625
- 27 MHz → 256/1125

Two word-wide write locations hold the ratio. Only the low 12 bits of each write are used. Software can change either value while the counter runs, and the count is never cleared or reloaded by such a write.

Top module: `frac_rate_counter`

## Requirements
- R1: While `rst_n` is low, and on the first edge after it rises, the count is 0 and the accumulator is 0. Reset loads step = 4 and modulus = 25, so with no writes the count first reads 1 after the 7th rising edge with `rst_n` high.
- R2: On every edge with a non-zero modulus, sum = accumulator + step. If sum ≥ modulus, the count increments by one and the accumulator becomes sum − modulus. Otherwise the count holds and the accumulator becomes sum.
- R3: With step < modulus held steady, and starting from accumulator value a, the count advances by exactly floor((a + N·step)/modulus) over N edges.
- R4: The count never advances by more than one per clock edge.
- R5: A write (`reg_we` high) to byte address 0x10 loads the step, and a write to 0x14 loads the modulus. Each value is taken from `reg_wdata[11:0]`; bits 31:12 of the write data have no effect.
- R6: Writes to any other address leave step, modulus, accumulator progression and count unaffected.
- R7: A written value is first used on the edge after the write edge, and the write does not clear the count or the accumulator.
- R8: While the modulus is 0, the count and the accumulator both hold their values.
- R9: If step ≥ modulus (modulus non-zero), the count increments on every edge. If sum − modulus is still ≥ modulus, the accumulator is set to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Input clock of arbitrary frequency |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 8 | Byte address of the write |
| reg_wdata | input | 32 | Write data; bits 11:0 used |
| count | output | 64 | Free-running time count |

## Verification
The bench drives several kinds of input pattern:

- **Long idle runs, one per ratio pair.** These are checked against the closed-form floor formula. They separate a correct carry-and-subtract from a one-off error in the compare or the remainder.
- **A reset-default run.** This pins the exact edge of the first increment.
- **Constrained random runs.** These mix writes whose upper bits are random, writes to unmapped addresses, a zero modulus and step-above-modulus cases. A cycle-accurate bench model exposes wrong decode, ignored bits that leak in, a wrong write latency and wrong hold behaviour.

// File: rtl/frac_rate_counter.sv
module frac_rate_counter #(
  parameter int CNT_W   = 64,
  parameter int FRAC_W  = 12,
  parameter int ADDR_W  = 8,
  parameter int DATA_W  = 32,
  parameter int STEP_OFS = 'h10,
  parameter int MOD_OFS  = 'h14,
  parameter int STEP_RST = 4,
  parameter int MOD_RST  = 25
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_we,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [CNT_W-1:0]  count
);
  localparam int SUM_W = FRAC_W + 1;

  logic [FRAC_W-1:0] step_q, mod_q, acc_q, acc_nxt;
  logic [SUM_W-1:0]  sum, rem;
  logic              run, carry;

  assign run   = mod_q != '0;
  assign sum   = {1'b0, acc_q} + {1'b0, step_q};
  assign carry = sum >= {1'b0, mod_q};
  assign rem   = carry ? sum - {1'b0, mod_q} : sum;
  assign acc_nxt = (rem >= {1'b0, mod_q}) ? '0 : rem[FRAC_W-1:0];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      step_q <= FRAC_W'(STEP_RST);
      mod_q  <= FRAC_W'(MOD_RST);
    end else if (reg_we) begin
      if (reg_addr == ADDR_W'(STEP_OFS)) step_q <= reg_wdata[FRAC_W-1:0];
      if (reg_addr == ADDR_W'(MOD_OFS))  mod_q  <= reg_wdata[FRAC_W-1:0];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      acc_q <= '0;
      count <= '0;
    end else if (run) begin
      acc_q <= acc_nxt;
      if (carry) count <= count + CNT_W'(1);
    end
  end

  // R4
  at_most_one_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (count == $past(count)) || (count == $past(count) + CNT_W'(1)));

  // R8
  zero_mod_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mod_q == '0) |=> ($stable(count) && $stable(acc_q)));

  // R2
  acc_below_mod_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mod_q != '0) |=> (acc_q < $past(mod_q)));

  // R9
  fast_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mod_q != '0 && step_q >= mod_q) |=> (count == $past(count) + CNT_W'(1)));

  // R6
  unmapped_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_we && reg_addr != ADDR_W'(STEP_OFS) && reg_addr != ADDR_W'(MOD_OFS))
      |=> ($stable(step_q) && $stable(mod_q)));
endmodule

// File: tb/frac_rate_counter_tb.sv
module frac_rate_counter_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_we = 1'b0;
  logic [7:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [63:0] count;

  int vectors = 0;
  int fails = 0;
  longint unsigned m_cnt, m_acc, m_step, m_mod;

  always #4 clk = ~clk;

  frac_rate_counter u_dut (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .count(count)
  );

  function automatic longint unsigned next_acc(longint unsigned a, longint unsigned s,
                                               longint unsigned m);
    longint unsigned t = a + s;
    if (t >= m) t = t - m;
    if (t >= m) t = 0;
    return t;
  endfunction

  task automatic check(string req, longint unsigned exp);
    vectors++;
    if (count !== exp) begin
      fails++;
      $display("FAIL %s: count=%0d expected=%0d", req, count, exp);
    end
  endtask

  // one clock: drive at negedge, model the edge, compare at next negedge
  task automatic cyc(bit we, logic [7:0] addr, logic [31:0] data, string req, bit chk = 1);
    reg_we = we; reg_addr = addr; reg_wdata = data;
    @(posedge clk);
    if (!rst_n) begin
      m_cnt = 0; m_acc = 0; m_step = 4; m_mod = 25;
    end else begin
      if (m_mod != 0) begin
        if (m_acc + m_step >= m_mod) m_cnt++;
        m_acc = next_acc(m_acc, m_step, m_mod);
      end
      if (we && addr == 8'h10) m_step = data[11:0];
      if (we && addr == 8'h14) m_mod  = data[11:0];
    end
    @(negedge clk);
    reg_we = 1'b0;
    if (chk) check(req, m_cnt);
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    cyc(0, 0, 0, "R1");
    cyc(0, 0, 0, "R1");
    rst_n = 1'b1;
  endtask

  task automatic ratio_run(int s, int m, int n);
    longint unsigned base;
    longint unsigned exp;
    do_reset();
    cyc(1, 8'h14, 32'h0, "R8");
    cyc(1, 8'h10, s, "R7");
    cyc(1, 8'h14, m, "R8");
    base = count;
    for (int i = 0; i < n; i++) cyc(0, 0, 0, "R2", 0);
    exp = base + (4 + longint'(n) * s) / m;
    check("R3", exp);
  endtask

  initial begin : watchdog
    repeat (190000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: expired, expected=finish");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    int pick;
    logic [31:0] d;
    @(negedge clk);
    do_reset();
    check("R1", 0);
    // R1: default 4/25, first increment after 7th edge
    for (int i = 0; i < 6; i++) cyc(0, 0, 0, "R1");
    check("R1", 0);
    cyc(0, 0, 0, "R1");
    check("R1", 1);
    for (int i = 0; i < 993; i++) cyc(0, 0, 0, "R2", 0);
    check("R3", 160);

    ratio_run(64, 125, 5000);
    ratio_run(768, 1625, 5000);
    ratio_run(8, 25, 5000);
    ratio_run(256, 1125, 3000);

    // R5: upper bits ignored
    do_reset();
    cyc(1, 8'h10, 32'hFFFF_F008, "R5");
    cyc(1, 8'h14, 32'hABCD_E019, "R5");
    for (int i = 0; i < 50; i++) cyc(0, 0, 0, "R5");
    // R6: unmapped writes
    cyc(1, 8'h11, 32'h0000_0FFF, "R6");
    cyc(1, 8'h18, 32'h0000_0000, "R6");
    cyc(1, 8'h04, 32'h0000_0001, "R6");
    for (int i = 0; i < 20; i++) cyc(0, 0, 0, "R6");
    // R8: zero modulus holds
    cyc(1, 8'h14, 32'h0, "R8");
    for (int i = 0; i < 20; i++) cyc(0, 0, 0, "R8");
    cyc(1, 8'h14, 32'd25, "R7");
    for (int i = 0; i < 20; i++) cyc(0, 0, 0, "R7");
    // R9: step above modulus, then modulus shrunk below accumulator
    cyc(1, 8'h10, 32'd30, "R9");
    for (int i = 0; i < 10; i++) cyc(0, 0, 0, "R9");
    cyc(1, 8'h10, 32'd20, "R9");
    cyc(0, 0, 0, "R9");
    cyc(1, 8'h14, 32'd3, "R9");
    for (int i = 0; i < 10; i++) cyc(0, 0, 0, "R4");

    // constrained random
    for (int i = 0; i < 6000; i++) begin
      pick = $urandom_range(0, 19);
      d = $urandom();
      if (pick == 0)      cyc(1, 8'h10, d, "R5");
      else if (pick == 1) cyc(1, 8'h14, (d[3:0] == 0) ? (d & 32'hFFFF_F000) : d, "R7");
      else if (pick == 2) cyc(1, 8'h10, {d[31:12], 12'(1 + d[5:0])}, "R2");
      else if (pick == 3) cyc(1, 8'h14, {d[31:12], 12'(64 + d[9:0])}, "R2");
      else if (pick == 4) cyc(1, 8'($urandom_range(0, 255)) & 8'hEB, d, "R6");
      else                cyc(0, 0, 0, "R4");
    end
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial void'($urandom(32'd1234));
endmodule